// File: doc/BRIEF.md
# PAM4 Transmit FIR Pre-Emphasis

This block sits on the transmit side of a serial link. It turns an incoming bit stream into line symbols and pre-distorts them so that a lossy channel returns a cleaner pulse. In four-level mode each pair of bits becomes one of four Gray-coded levels. In binary mode each bit becomes one of two levels. Each symbol passes through a five-tap FIR: one tap looks one symbol ahead (pre-cursor), one is the main cursor, and three look back (post-cursor). The result is a signed DAC code, clamped so that the peak swing stays within the converter's range.

The filter needs the following symbol to form the pre-cursor term, so every output lags its own symbol by one symbol period. Coefficients are signed, quantized values. They can be changed only while the filter is frozen by a hold input, so a symbol is never filtered with a mix of old and new taps.

Top module: `pam4_tx_fir`

## Requirements
- R1: After reset `dac_code` is 0 and `dac_vld` is 0. The symbol history is all zero. Coefficient 1 (main) is 2^(CW-2) (16 by default) and the other coefficients are 0.
- R2: With `pam4_en` low, each accepted bit forms one symbol: 0 gives level -1 and 1 gives level +1.
- R3: With `pam4_en` high, two accepted bits form one symbol and the first bit is the MSB. Pair 00 gives -3, 01 gives -1, 11 gives +1 and 10 gives +3.
- R4: When a symbol completes, the output is c0*s(n) + c1*s(n-1) + c2*s(n-2) + c3*s(n-3) + c4*s(n-4), where s(n) is the newest symbol. Coefficient index 0 is the pre-cursor tap, index 1 the main tap and indices 2 to 4 the post-cursor taps.
- R5: `dac_vld` is a one-cycle pulse in the cycle after the clock edge that accepted the bit completing a symbol. `dac_code` changes only with that pulse.
- R6: The FIR sum is saturated to the range -(2^(DW-1)-1) to +(2^(DW-1)-1), which is ±127 by default.
- R7: While `hold` is high, input bits are ignored, no output is produced and the symbol history is kept. A half-formed four-level symbol is discarded, and it is also discarded whenever `pam4_en` is low.
- R8: `coef_we` with `hold` high writes `coef_val` to coefficient `coef_sel` at the clock edge. A `coef_sel` value of 5 or more is ignored.
- R9: `coef_we` while `hold` is low leaves every coefficient unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pam4_en | input | 1 | 1: four-level symbols, 0: binary symbols |
| hold | input | 1 | Freezes the filter and enables coefficient writes |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | `bit_in` is valid this cycle |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient index (0 pre, 1 main, 2..4 post) |
| coef_val | input | CW (6) | Signed coefficient value |
| dac_code | output | DW (8) | Signed, saturated DAC code |
| dac_vld | output | 1 | One-cycle pulse marking a new `dac_code` |

## Verification
A bit that completes a symbol is registered at one rising edge. The new code and the `dac_vld` pulse then appear immediately after that edge and last for exactly one cycle. The bench drives each bit at a falling edge and samples the outputs at the next falling edge, so each check falls inside the one cycle in which the pulse is valid. When a bit only half-forms a four-level symbol, or arrives while `hold` is high, the same sample point must show `dac_vld` low. The effect of a coefficient write is checked on the next completed symbol, compared against a reference model kept in the bench.

// File: rtl/pam4_fir_pkg.sv
package pam4_fir_pkg;

    localparam int SYM_W = 3;

    typedef logic signed [SYM_W-1:0] sym_t;

    // Gray order of levels, lowest to highest: 00, 01, 11, 10
    function automatic sym_t pam4_level(input logic msb, input logic lsb);
        sym_t lvl;
        case ({msb, lsb})
            2'b00:   lvl = -3'sd3;
            2'b01:   lvl = -3'sd1;
            2'b11:   lvl = 3'sd1;
            default: lvl = 3'sd3;
        endcase
        return lvl;
    endfunction

    function automatic sym_t nrz_level(input logic b);
        return b ? 3'sd1 : -3'sd1;
    endfunction

endpackage

// File: rtl/pam4_sym_mapper.sv
module pam4_sym_mapper
    import pam4_fir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic pam4_en,
    input  logic bit_in,
    input  logic bit_vld,
    output logic sym_stb,
    output sym_t sym_val
);

    typedef struct packed {
        logic half;
        logic msb;
    } map_st_t;

    map_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        sym_stb = 1'b0;
        sym_val = pam4_en ? pam4_level(st_q.msb, bit_in) : nrz_level(bit_in);
        if (hold || !pam4_en) begin
            st_d.half = 1'b0;
            sym_stb   = !hold && bit_vld;
        end else if (bit_vld) begin
            if (!st_q.half) begin
                st_d.half = 1'b1;
                st_d.msb  = bit_in;
            end else begin
                st_d.half = 1'b0;
                sym_stb   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the first bit of a pair always leaves a pending half symbol
    a_r3_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (pam4_en && !hold && bit_vld && !st_q.half) |=> st_q.half);

    // R7: nothing stays pending across a hold
    a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !st_q.half);

endmodule

// File: rtl/pam4_coef_bank.sv
module pam4_coef_bank #(
    parameter int NTAP = 5,
    parameter int CW   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold,
    input  logic                          coef_we,
    input  logic [$clog2(NTAP+1)-1:0]     coef_sel,
    input  logic [CW-1:0]                 coef_val,
    output logic [NTAP-1:0][CW-1:0]       coefs
);

    localparam int MAIN_IDX = 1;
    localparam logic [CW-1:0] MAIN_RST = CW'(1 << (CW-2));

    typedef struct packed {
        logic [NTAP-1:0][CW-1:0] c;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (coef_we && hold && (int'(coef_sel) < NTAP))
            st_d.c[coef_sel] = coef_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP; i++)
                st_q.c[i] <= (i == MAIN_IDX) ? MAIN_RST : '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coefs = st_q.c;

    // R9: coefficients are frozen whenever the filter runs
    a_r9_coef_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(coefs));

endmodule

// File: rtl/pam4_fir_core.sv
module pam4_fir_core
    import pam4_fir_pkg::*;
#(
    parameter int NTAP = 5,
    parameter int CW   = 6,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_stb,
    input  sym_t                    sym_val,
    input  logic [NTAP-1:0][CW-1:0] coefs,
    output logic signed [DW-1:0]    dac_code,
    output logic                    dac_vld
);

    localparam int ACCW = CW + SYM_W + $clog2(NTAP) + 1;
    localparam logic signed [ACCW-1:0] LIM = ACCW'((1 << (DW-1)) - 1);

    typedef struct packed {
        logic [NTAP-1:0][SYM_W-1:0] hist;
        logic [DW-1:0]              code;
        logic                       vld;
    } fir_st_t;

    fir_st_t st_d, st_q;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] cext;
    logic signed [ACCW-1:0] sext;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (sym_stb) begin
            st_d.hist[0] = sym_val;
            for (int i = 1; i < NTAP; i++)
                st_d.hist[i] = st_q.hist[i-1];
        end
        // index 0 sees the newest symbol: the pre-cursor tap
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            cext = ACCW'($signed(coefs[i]));
            sext = ACCW'($signed(st_d.hist[i]));
            acc  = acc + cext * sext;
        end
        if (sym_stb) begin
            st_d.vld = 1'b1;
            if (acc > LIM)       st_d.code = LIM[DW-1:0];
            else if (acc < -LIM) st_d.code = (-LIM);
            else                 st_d.code = acc[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_code = $signed(st_q.code);
    assign dac_vld  = st_q.vld;

    // R5: a completed symbol yields a pulse one edge later
    a_r5_stb_to_vld: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> dac_vld);

    // R5: the code holds between symbols
    a_r5_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> $stable(dac_code));

    // R6: the code never leaves the symmetric DAC range
    a_r6_within_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ACCW'(dac_code) <= LIM) && (ACCW'(dac_code) >= -LIM));

endmodule

// File: rtl/pam4_tx_fir.sv
module pam4_tx_fir
    import pam4_fir_pkg::*;
#(
    parameter int NTAP = 5,
    parameter int CW   = 6,
    parameter int DW   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pam4_en,
    input  logic                          hold,
    input  logic                          bit_in,
    input  logic                          bit_vld,
    input  logic                          coef_we,
    input  logic [$clog2(NTAP+1)-1:0]     coef_sel,
    input  logic [CW-1:0]                 coef_val,
    output logic signed [DW-1:0]          dac_code,
    output logic                          dac_vld
);

    logic                    sym_stb;
    sym_t                    sym_val;
    logic [NTAP-1:0][CW-1:0] coefs;

    pam4_sym_mapper u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .pam4_en (pam4_en),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .sym_stb (sym_stb),
        .sym_val (sym_val)
    );

    pam4_coef_bank #(.NTAP(NTAP), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .coef_we  (coef_we),
        .coef_sel (coef_sel),
        .coef_val (coef_val),
        .coefs    (coefs)
    );

    pam4_fir_core #(.NTAP(NTAP), .CW(CW), .DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_stb  (sym_stb),
        .sym_val  (sym_val),
        .coefs    (coefs),
        .dac_code (dac_code),
        .dac_vld  (dac_vld)
    );

    // R7: a held filter emits nothing
    a_r7_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !dac_vld);

endmodule

// File: tb/pam4_tx_fir_tb_top.sv
module pam4_tx_fir_tb_top;

    localparam int NTAP = 5;
    localparam int CW   = 6;
    localparam int DW   = 8;
    localparam int LIM  = (1 << (DW-1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pam4_en = 1'b0;
    logic hold = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic coef_we = 1'b0;
    logic [2:0] coef_sel = '0;
    logic [CW-1:0] coef_val = '0;
    logic signed [DW-1:0] dac_code;
    logic dac_vld;

    int n_chk = 0;
    int n_fail = 0;

    int mc [NTAP];
    int mh [NTAP];
    int m_half = 0;
    int m_msb = 0;

    always #2.5 clk = ~clk;

    pam4_tx_fir #(.NTAP(NTAP), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pam4_en(pam4_en), .hold(hold),
        .bit_in(bit_in), .bit_vld(bit_vld), .coef_we(coef_we),
        .coef_sel(coef_sel), .coef_val(coef_val),
        .dac_code(dac_code), .dac_vld(dac_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_out();
        int s = 0;
        for (int i = 0; i < NTAP; i++) s += mc[i] * mh[i];
        if (s > LIM) s = LIM;
        if (s < -LIM) s = -LIM;
        return s;
    endfunction

    function automatic int gray_lvl(input int msb, input int lsb);
        case ({msb[0], lsb[0]})
            2'b00: return -3;
            2'b01: return -1;
            2'b11: return 1;
            default: return 3;
        endcase
    endfunction

    // Sends one bit; checks the pulse and code in the cycle they are due
    task automatic send_bit(input int b, input string req);
        int sym;
        bit done;
        int prev;
        prev = int'(dac_code);
        @(negedge clk);
        bit_in = b[0];
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        done = 0;
        if (hold) begin
            done = 0;
        end else if (!pam4_en) begin
            sym = b ? 1 : -1;
            done = 1;
        end else if (m_half == 0) begin
            m_half = 1;
            m_msb = b;
        end else begin
            m_half = 0;
            sym = gray_lvl(m_msb, b);
            done = 1;
        end
        if (done) begin
            for (int i = NTAP-1; i > 0; i--) mh[i] = mh[i-1];
            mh[0] = sym;
            check(req, int'(dac_vld), 1);
            check(req, int'(dac_code), model_out());
        end else begin
            check(req, int'(dac_vld), 0);
            check(req, int'(dac_code), prev);
        end
    endtask

    task automatic set_hold(input bit v);
        @(negedge clk);
        hold = v;
        if (v) m_half = 0;
    endtask

    task automatic set_mode(input bit p);
        @(negedge clk);
        pam4_en = p;
        m_half = 0;
    endtask

    task automatic write_coef(input int idx, input int val);
        @(negedge clk);
        coef_we = 1'b1;
        coef_sel = idx[2:0];
        coef_val = val[CW-1:0];
        @(negedge clk);
        coef_we = 1'b0;
        if (hold && idx < NTAP) mc[idx] = val;
    endtask

    task automatic t_reset();
        check("R1", int'(dac_code), 0);
        check("R1", int'(dac_vld), 0);
    endtask

    task automatic t_nrz();
        set_mode(1'b0);
        // with only the main tap at 16: first bit hits the pre-cursor tap (0)
        send_bit(1, "R1");
        send_bit(0, "R2");
        send_bit(1, "R2");
        send_bit(1, "R2");
        send_bit(0, "R5");
    endtask

    task automatic t_pam4_levels();
        set_mode(1'b1);
        send_bit(0, "R3"); send_bit(0, "R3");
        send_bit(0, "R3"); send_bit(1, "R3");
        send_bit(1, "R3"); send_bit(1, "R3");
        send_bit(1, "R3"); send_bit(0, "R3");
        send_bit(0, "R3"); send_bit(0, "R3");
    endtask

    task automatic t_taps();
        set_hold(1'b1);
        write_coef(0, -8);
        write_coef(1, 20);
        write_coef(2, -5);
        write_coef(3, 3);
        write_coef(4, -2);
        write_coef(7, 31);   // R8 out-of-range index
        set_hold(1'b0);
        set_mode(1'b0);
        send_bit(1, "R4"); send_bit(1, "R4"); send_bit(0, "R4");
        send_bit(1, "R4"); send_bit(0, "R4"); send_bit(0, "R8");
        set_mode(1'b1);
        send_bit(1, "R4"); send_bit(0, "R4");
        send_bit(0, "R4"); send_bit(1, "R4");
    endtask

    task automatic t_write_blocked();
        write_coef(1, -30);   // hold low: R9 says no effect
        set_mode(1'b0);
        send_bit(1, "R9");
        send_bit(1, "R9");
    endtask

    task automatic t_hold();
        set_mode(1'b1);
        send_bit(1, "R7");          // half symbol pending
        set_hold(1'b1);
        send_bit(0, "R7");
        send_bit(1, "R7");
        set_hold(1'b0);
        send_bit(0, "R7");          // fresh pair: 01 -> -1
        send_bit(1, "R7");
    endtask

    task automatic t_saturate();
        set_hold(1'b1);
        for (int i = 0; i < NTAP; i++) write_coef(i, 31);
        set_hold(1'b0);
        set_mode(1'b1);
        for (int k = 0; k < 5; k++) begin
            send_bit(1, "R6"); send_bit(0, "R6");
        end
        check("R6", int'(dac_code), LIM);
        for (int k = 0; k < 5; k++) begin
            send_bit(0, "R6"); send_bit(0, "R6");
        end
        check("R6", int'(dac_code), -LIM);
    endtask

    initial begin
        for (int i = 0; i < NTAP; i++) begin
            mc[i] = (i == 1) ? (1 << (CW-2)) : 0;
            mh[i] = 0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nrz();
        t_pam4_levels();
        t_taps();
        t_write_blocked();
        t_hold();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule